// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for each incoming Ethernet frame, whether the frame should be kept, and reports which rule let it through. The receive path presents the 48-bit destination address and the 16-bit type/length field together with a one-cycle strobe. The block compares them against its configuration:

- four programmable station addresses,
- four programmable type values,
- a 64-entry hash table that can be enabled separately for unicast and multicast frames,
- a broadcast rule,
- a promiscuous mode,
- an external match input from a neighbouring filter.

All accept paths are evaluated in parallel. The winning rule is reduced to one 4-bit reason code so that a later stage can store it alongside the frame in its descriptor. Accept and reason are registered and appear exactly one clock after the strobe. One frame can be filtered every cycle.

Top module: `rx_addr_filter`

## Requirements
- R1: A frame is accepted when its destination address equals station slot n (n = 0..3) and `saEnable[n]` is 1. The slot address is `{saHigh[16n+15:16n], saLow[32n+31:32n]}`, with the high part forming address bits 47:32.
- R2: A station slot whose enable bit is 0 never matches, whatever value it holds.
- R3: A frame is accepted when its type/length field equals `tidValue[16n+15:16n]` and `tidEnable[n]` is 1.
- R4: Hash index and frame class are defined as follows:
  - The hash index is the XOR of the eight 6-bit slices `dstAddr[6k+5:6k]`, k = 0..7.
  - A frame is multicast when `dstAddr[40]` (bit 0 of the first transmitted octet, held in bits 47:40) is 1, and unicast otherwise.
  - The all-ones address counts as multicast.
- R5: The hash path accepts a multicast frame only when `mcHashEn` is 1 and `hashTable[index]` is 1. It accepts a unicast frame only when `ucHashEn` is 1 and `hashTable[index]` is 1.
- R6: Destination address 0xFFFFFFFFFFFF is accepted as broadcast unless `noBroadcast` is 1.
- R7: When `copyAll` is 1, every frame is accepted.
- R8: When `extMatch` is 1 with the strobe, the frame is accepted.
- R9: The reason code gives the highest-priority rule that matched, from highest to lowest:
  - station slots 0..3 give codes 1..4,
  - type slots 0..3 give codes 5..8,
  - hash gives 9,
  - broadcast gives 10,
  - external match gives 11,
  - copy-all gives 12.
- R10: When no rule matches, `accept` is 0 and `reason` is 0 in the result cycle.
- R11: `outValid`, `accept` and `reason` appear on the first rising edge after the strobe. They are 0 in any cycle that does not follow a strobe. `accept` is 1 exactly when `reason` is nonzero.
- R12: After reset, `outValid`, `accept` and `reason` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameValid | input | 1 | One-cycle strobe marking a frame header to filter |
| dstAddr | input | 48 | Destination address, first octet in bits 47:40 |
| typeLen | input | 16 | Type/length field |
| extMatch | input | 1 | Match indication from an external filter |
| saLow | input | 128 | Low 32 bits of the four station addresses |
| saHigh | input | 64 | High 16 bits of the four station addresses |
| saEnable | input | 4 | Per-slot station address enables |
| tidValue | input | 64 | Four 16-bit type values |
| tidEnable | input | 4 | Per-slot type value enables |
| hashTable | input | 64 | Hash table, one bit per index |
| ucHashEn | input | 1 | Enable hash acceptance of unicast frames |
| mcHashEn | input | 1 | Enable hash acceptance of multicast frames |
| noBroadcast | input | 1 | Reject broadcast frames on the broadcast rule |
| copyAll | input | 1 | Promiscuous mode |
| outValid | output | 1 | Result strobe, one cycle after frameValid |
| accept | output | 1 | Frame accepted |
| reason | output | 4 | Encoded match reason, 0 when none |

## Verification
Every result is due exactly one rising edge after the strobe. The bench drives inputs on the falling edge and raises `frameValid` there. It captures the expected code from its own model at that moment and compares all three outputs on the next falling edge, by which time the single register stage has updated. Between frames the strobe is low for a cycle. The bench uses that idle cycle, with `copyAll` set, to confirm that nothing is reported when no strobe preceded it.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int SLOTS    = 4;
  localparam int REASON_W = 4;

  typedef logic [REASON_W-1:0] reason_t;

  localparam reason_t RSN_NONE     = 4'd0;
  localparam reason_t RSN_SA_BASE  = 4'd1;
  localparam reason_t RSN_TID_BASE = 4'd5;
  localparam reason_t RSN_HASH     = 4'd9;
  localparam reason_t RSN_BCAST    = 4'd10;
  localparam reason_t RSN_EXT      = 4'd11;
  localparam reason_t RSN_ALL      = 4'd12;

  // Match strobes handed from datapath to control
  typedef struct packed {
    logic [SLOTS-1:0] saHit;
    logic [SLOTS-1:0] tidHit;
    logic             hashHit;
    logic             bcastHit;
    logic             extHit;
    logic             allHit;
  } hit_t;
endpackage

// File: rtl/rxf_match_dp.sv
module rxf_match_dp
  import rxf_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int HIGH_W    = 16,
  parameter int TYPE_W    = 16,
  parameter int HASH_BITS = 6
) (
  input  logic [ADDR_W-1:0]              dstAddr,
  input  logic [TYPE_W-1:0]              typeLen,
  input  logic                           extMatch,
  input  logic [SLOTS*(ADDR_W-HIGH_W)-1:0] saLow,
  input  logic [SLOTS*HIGH_W-1:0]        saHigh,
  input  logic [SLOTS-1:0]               saEnable,
  input  logic [SLOTS*TYPE_W-1:0]        tidValue,
  input  logic [SLOTS-1:0]               tidEnable,
  input  logic [(1<<HASH_BITS)-1:0]      hashTable,
  input  logic                           ucHashEn,
  input  logic                           mcHashEn,
  input  logic                           noBroadcast,
  input  logic                           copyAll,
  output hit_t                           hits
);
  localparam int LOW_W  = ADDR_W - HIGH_W;
  localparam int SLICES = ADDR_W / HASH_BITS;
  localparam int MC_BIT = ADDR_W - 8;

  logic [SLOTS-1:0]     saVec;
  logic [SLOTS-1:0]     tidVec;
  logic [HASH_BITS-1:0] hashIdx;
  logic                 isMulti;
  logic                 isBcast;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign saVec[g]  = saEnable[g] &&
                       (dstAddr == {saHigh[g*HIGH_W +: HIGH_W], saLow[g*LOW_W +: LOW_W]});
    assign tidVec[g] = tidEnable[g] && (typeLen == tidValue[g*TYPE_W +: TYPE_W]);
  end

  always_comb begin
    hashIdx = '0;
    for (int k = 0; k < SLICES; k++) begin
      hashIdx = hashIdx ^ dstAddr[k*HASH_BITS +: HASH_BITS];
    end
  end

  assign isMulti = dstAddr[MC_BIT];
  assign isBcast = &dstAddr;

  always_comb begin
    hits          = '0;
    hits.saHit    = saVec;
    hits.tidHit   = tidVec;
    hits.hashHit  = hashTable[hashIdx] && (isMulti ? mcHashEn : ucHashEn);
    hits.bcastHit = isBcast && !noBroadcast;
    hits.extHit   = extMatch;
    hits.allHit   = copyAll;
  end
endmodule

// File: rtl/rxf_prio_ctrl.sv
module rxf_prio_ctrl
  import rxf_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameValid,
  input  hit_t    hits,
  output logic    outValid,
  output logic    accept,
  output reason_t reason
);
  reason_t nextReason;

  // Lowest priority assigned first; later assignments override
  always_comb begin
    nextReason = RSN_NONE;
    if (hits.allHit)   nextReason = RSN_ALL;
    if (hits.extHit)   nextReason = RSN_EXT;
    if (hits.bcastHit) nextReason = RSN_BCAST;
    if (hits.hashHit)  nextReason = RSN_HASH;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (hits.tidHit[i]) nextReason = reason_t'(RSN_TID_BASE + reason_t'(i));
    end
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (hits.saHit[i]) nextReason = reason_t'(RSN_SA_BASE + reason_t'(i));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      accept   <= 1'b0;
      reason   <= RSN_NONE;
    end else begin
      outValid <= frameValid;
      accept   <= frameValid && (nextReason != RSN_NONE);
      reason   <= frameValid ? nextReason : RSN_NONE;
    end
  end

  p_latency_r11: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> outValid);
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!accept && reason == RSN_NONE));
  p_promisc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && hits.allHit) |=> accept);
  p_slot0_first_r9: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && hits.saHit[0]) |=> (reason == RSN_SA_BASE));
  p_code_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    reason <= RSN_ALL);
  p_accept_code_r11: assert property (@(posedge clk) disable iff (!rstN)
    accept == (reason != RSN_NONE));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int HIGH_W    = 16,
  parameter int TYPE_W    = 16,
  parameter int HASH_BITS = 6,
  localparam int LOW_W    = ADDR_W - HIGH_W,
  localparam int TABLE_N  = 1 << HASH_BITS
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        frameValid,
  input  logic [ADDR_W-1:0]           dstAddr,
  input  logic [TYPE_W-1:0]           typeLen,
  input  logic                        extMatch,
  input  logic [SLOTS*LOW_W-1:0]      saLow,
  input  logic [SLOTS*HIGH_W-1:0]     saHigh,
  input  logic [SLOTS-1:0]            saEnable,
  input  logic [SLOTS*TYPE_W-1:0]     tidValue,
  input  logic [SLOTS-1:0]            tidEnable,
  input  logic [TABLE_N-1:0]          hashTable,
  input  logic                        ucHashEn,
  input  logic                        mcHashEn,
  input  logic                        noBroadcast,
  input  logic                        copyAll,
  output logic                        outValid,
  output logic                        accept,
  output logic [REASON_W-1:0]         reason
);
  hit_t hits;

  rxf_match_dp #(
    .ADDR_W(ADDR_W), .HIGH_W(HIGH_W), .TYPE_W(TYPE_W), .HASH_BITS(HASH_BITS)
  ) u_dp (
    .dstAddr(dstAddr), .typeLen(typeLen), .extMatch(extMatch),
    .saLow(saLow), .saHigh(saHigh), .saEnable(saEnable),
    .tidValue(tidValue), .tidEnable(tidEnable), .hashTable(hashTable),
    .ucHashEn(ucHashEn), .mcHashEn(mcHashEn), .noBroadcast(noBroadcast),
    .copyAll(copyAll), .hits(hits)
  );

  rxf_prio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .hits(hits),
    .outValid(outValid), .accept(accept), .reason(reason)
  );
endmodule

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameValid = 1'b0;
  logic [47:0] dstAddr = '0;
  logic [15:0] typeLen = '0;
  logic extMatch = 1'b0;
  logic [127:0] saLow = '0;
  logic [63:0] saHigh = '0;
  logic [3:0] saEnable = '0;
  logic [63:0] tidValue = '0;
  logic [3:0] tidEnable = '0;
  logic [63:0] hashTable = '0;
  logic ucHashEn = 1'b0, mcHashEn = 1'b0, noBroadcast = 1'b0, copyAll = 1'b0;
  logic outValid, accept;
  logic [3:0] reason;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  rx_addr_filter u0 (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .dstAddr(dstAddr),
    .typeLen(typeLen), .extMatch(extMatch), .saLow(saLow), .saHigh(saHigh),
    .saEnable(saEnable), .tidValue(tidValue), .tidEnable(tidEnable),
    .hashTable(hashTable), .ucHashEn(ucHashEn), .mcHashEn(mcHashEn),
    .noBroadcast(noBroadcast), .copyAll(copyAll),
    .outValid(outValid), .accept(accept), .reason(reason)
  );

  always #2.5 clk = ~clk;

  function automatic logic [47:0] slotAddr(int n);
    return {saHigh[n*16 +: 16], saLow[n*32 +: 32]};
  endfunction

  function automatic logic [5:0] hashOf(logic [47:0] a);
    logic [5:0] h = '0;
    for (int k = 0; k < 8; k++) h = h ^ 6'((a >> (6*k)) & 48'h3f);
    return h;
  endfunction

  // Expected reason from the requirements, priority order of R9
  function automatic logic [3:0] model();
    bit multi = dstAddr[40];
    for (int n = 0; n < 4; n++)
      if (saEnable[n] && dstAddr == slotAddr(n)) return 4'(1 + n);
    for (int n = 0; n < 4; n++)
      if (tidEnable[n] && typeLen == tidValue[n*16 +: 16]) return 4'(5 + n);
    if (hashTable[hashOf(dstAddr)] && (multi ? mcHashEn : ucHashEn)) return 4'd9;
    if (dstAddr == 48'hFFFF_FFFF_FFFF && !noBroadcast) return 4'd10;
    if (extMatch) return 4'd11;
    if (copyAll) return 4'd12;
    return 4'd0;
  endfunction

  task automatic check(string tag, logic [5:0] got, logic [5:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, want);
    end
  endtask

  task automatic runFrame(string tag);
    logic [3:0] exp;
    @(negedge clk);
    frameValid = 1'b1;
    exp = model();
    @(negedge clk);
    frameValid = 1'b0;
    check({tag, " valid R11"}, {5'd0, outValid}, 6'd1);
    check({tag, " reason"}, {2'd0, reason}, {2'd0, exp});
    check({tag, " accept R11"}, {5'd0, accept}, {5'd0, exp != 0});
  endtask

  task automatic clearCfg();
    saEnable = '0; tidEnable = '0; hashTable = '0; ucHashEn = 0; mcHashEn = 0;
    noBroadcast = 0; copyAll = 0; extMatch = 0;
  endtask

  initial begin
    for (int n = 0; n < 4; n++) begin
      saLow[n*32 +: 32]    = 32'h1000_0000 + 32'(n * 32'h0101_0101);
      saHigh[n*16 +: 16]   = 16'h0220 + 16'(n * 2);
      tidValue[n*16 +: 16] = 16'h0800 + 16'(n * 16'h0111);
    end
    #12;
    check("R12 valid", {5'd0, outValid}, 6'd0);
    check("R12 accept", {5'd0, accept}, 6'd0);
    check("R12 reason", {2'd0, reason}, 6'd0);
    @(negedge clk); rstN = 1'b1;

    // R1 / R2: every slot against every enable mask
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 16; m++) begin
        clearCfg(); saEnable = 4'(m); dstAddr = slotAddr(s); typeLen = 16'h1234;
        runFrame(m[s] ? "R1" : "R2");
      end
    end
    // R3: every type slot against every enable mask
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 16; m++) begin
        clearCfg(); tidEnable = 4'(m); dstAddr = 48'h0A00_0000_0001;
        typeLen = tidValue[s*16 +: 16];
        runFrame("R3");
      end
    end
    // R4 / R5: hash sweep over classes and enables
    for (int i = 0; i < 256; i++) begin
      clearCfg();
      hashTable = {$urandom, $urandom};
      dstAddr = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      ucHashEn = i[0]; mcHashEn = i[1];
      typeLen = 16'h1234;
      runFrame("R4 R5");
    end
    // R6: broadcast with and without block, and hash ahead of broadcast (R9)
    clearCfg(); dstAddr = 48'hFFFF_FFFF_FFFF; runFrame("R6");
    noBroadcast = 1; runFrame("R6 blocked");
    noBroadcast = 0; mcHashEn = 1; hashTable = 64'h1; runFrame("R9 hash before bcast");
    // R7 / R8 / R10
    clearCfg(); dstAddr = 48'h0200_0000_0055; copyAll = 1; runFrame("R7");
    copyAll = 0; extMatch = 1; runFrame("R8");
    copyAll = 1; runFrame("R9 ext before all");
    clearCfg(); runFrame("R10");
    // R11: no strobe, copyAll on, outputs must stay quiet
    copyAll = 1;
    @(negedge clk);
    check("R11 idle valid", {5'd0, outValid}, 6'd0);
    check("R11 idle accept", {5'd0, accept}, 6'd0);
    check("R11 idle reason", {2'd0, reason}, 6'd0);
    // R9: mixed random configurations
    for (int i = 0; i < 400; i++) begin
      saEnable = 4'($urandom); tidEnable = 4'($urandom);
      hashTable = {$urandom, $urandom};
      ucHashEn = 1'($urandom); mcHashEn = 1'($urandom);
      noBroadcast = 1'($urandom); copyAll = 1'($urandom % 4 == 0);
      extMatch = 1'($urandom % 3 == 0);
      case ($urandom % 4)
        0: dstAddr = slotAddr(int'($urandom % 4));
        1: dstAddr = 48'hFFFF_FFFF_FFFF;
        default: dstAddr = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      endcase
      typeLen = ($urandom % 2) ? tidValue[($urandom % 4)*16 +: 16] : 16'($urandom);
      runFrame("R9");
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule